// File: doc/BRIEF.md
# Bit-Field Extract/Insert Execution Unit

This unit is one execution lane of a 32-bit soft processor. It takes a decoded-stage instruction word together with the value of its source register and the current value of its destination register. It recognises two immediate bit-field operations that share one major opcode and differ in bits 15:14. Extract pulls a field of chosen width and offset out of the source and returns it right-aligned with zeros above. Insert places the low bits of the source into the old destination value at a chosen offset and leaves every other bit untouched.

The two operations fill their 5-bit immediate in bits 10:6 differently. For extract that field is the width. For insert it is the index of the field's top bit, so the unit derives the insert width from that index and the offset. Encodings that break the width rules, and words outside the class, are flagged and never write back. Results are registered once, so a request on one cycle appears at the outputs on the next.

Top module: `bitfield_xu`

## Requirements
- R1: A word is an extract when (word & 0xFC00C000) == 0x64004000 and an insert when it equals 0x64008000. Bits 4:0 hold the offset, bits 10:6 hold the shared immediate. The write enable and the illegal flag are never high together.
- R2: A legal extract returns source bits [offset+width-1 : offset] in result bits [width-1:0], with every higher result bit zero. Here width is bits 10:6.
- R3: A legal insert returns the old destination with bits [top:offset] replaced by source bits [top-offset:0]. Here top is bits 10:6 and the width is top-offset+1. All other bits keep their old destination value.
- R4: The destination index output equals bits 25:21 of the accepted word, for every accepted word.
- R5: An extract whose bits 10:6 are zero sets the illegal flag, clears the write enable, and drives a zero result.
- R6: An extract whose width plus offset exceeds 32 sets the illegal flag, clears the write enable, and drives a zero result.
- R7: An insert whose bits 10:6 are below its offset sets the illegal flag, clears the write enable, and drives a zero result.
- R8: A valid word that matches neither pattern sets the illegal flag, clears the write enable, and drives a zero result.
- R9: Outputs change one clock after a valid request. A cycle without valid leaves write enable and illegal low on the next cycle, and the result and index keep their values.
- R10: A synchronous reset clears the write enable, the illegal flag, the result and the index.
- R11: An insert with offset 0 and top 31 replaces all 32 destination bits with the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_instr | input | 32 | Instruction word |
| in_src | input | 32 | Source register value |
| in_dst | input | 32 | Current destination register value |
| out_result | output | 32 | Registered write-back data |
| out_rd | output | 5 | Registered destination index |
| out_we | output | 1 | Registered write enable |
| out_illegal | output | 1 | Registered illegal-encoding flag |

## Verification
The properties assume that the instruction, source and destination inputs are known whenever valid is high. They also assume valid is not left undefined after reset. Both are true of the bench, which drives every input on the falling edge from definite values. The bench steers its random immediates toward the edges: zero and near-32 widths, offsets above the insert top, and full-word fields. About one request in eight is idle, so the hold behaviour is exercised between real requests.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    localparam int unsigned XLEN     = 32;
    localparam int unsigned IDX_W    = 5;
    localparam int unsigned SHAMT_W  = $clog2(XLEN);
    localparam int unsigned WIDTH_W  = SHAMT_W + 1;

    localparam logic [31:0] CLASS_MASK  = 32'hFC00_C000;
    localparam logic [31:0] EXTRACT_PAT = 32'h6400_4000;
    localparam logic [31:0] INSERT_PAT  = 32'h6400_8000;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_EXTRACT = 2'd1,
        OP_INSERT  = 2'd2
    } bf_op_e;

    typedef struct packed {
        bf_op_e               op;
        logic [IDX_W-1:0]     rd;
        logic [SHAMT_W-1:0]   offset;
        logic [WIDTH_W-1:0]   width;
        logic                 legal;
    } bf_dec_t;

    typedef struct packed {
        logic [XLEN-1:0]  result;
        logic [IDX_W-1:0] rd;
        logic             we;
        logic             illegal;
    } bf_out_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
(
    input  logic [31:0] instr,
    output bf_dec_t     dec
);
    logic [SHAMT_W-1:0] imm_hi;
    logic [SHAMT_W-1:0] imm_off;
    logic [WIDTH_W-1:0] span_sum;
    logic [WIDTH_W-1:0] ins_width;
    logic               is_ext;
    logic               is_ins;
    logic               unused_bits;

    assign imm_hi    = instr[10:6];
    assign imm_off   = instr[4:0];
    assign is_ext    = (instr & CLASS_MASK) == EXTRACT_PAT;
    assign is_ins    = (instr & CLASS_MASK) == INSERT_PAT;
    assign span_sum  = {1'b0, imm_hi} + {1'b0, imm_off};
    assign ins_width = {1'b0, imm_hi} - {1'b0, imm_off} + WIDTH_W'(1);
    assign unused_bits = ^{instr[20:16], instr[13:11], instr[5]};

    always_comb begin
        dec        = '0;
        dec.rd     = instr[25:21];
        dec.offset = imm_off;
        if (is_ext) begin
            dec.op    = OP_EXTRACT;
            dec.width = {1'b0, imm_hi};
            dec.legal = (imm_hi != '0) && (span_sum <= WIDTH_W'(XLEN));
        end else if (is_ins) begin
            dec.op    = OP_INSERT;
            dec.width = ins_width;
            dec.legal = imm_hi >= imm_off;
        end else begin
            dec.op    = OP_NONE;
            dec.legal = 1'b0;
        end
    end
endmodule

// File: rtl/bfx_mask.sv
module bfx_mask
    import bfx_pkg::*;
(
    input  logic [WIDTH_W-1:0] width,
    input  logic [SHAMT_W-1:0] shift,
    output logic [XLEN-1:0]    mask
);
    logic [XLEN:0] low_ones;
    logic [XLEN:0] placed;
    logic          unused_top;

    assign low_ones   = ((XLEN+1)'(1) << width) - (XLEN+1)'(1);
    assign placed     = low_ones << shift;
    assign mask       = placed[XLEN-1:0];
    assign unused_top = placed[XLEN];
endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
    import bfx_pkg::*;
(
    input  bf_dec_t         dec,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] dst,
    output logic [XLEN-1:0] value
);
    logic [SHAMT_W-1:0] mask_shift;
    logic [XLEN-1:0]    mask;
    logic [XLEN-1:0]    src_down;
    logic [XLEN-1:0]    src_up;

    assign mask_shift = (dec.op == OP_INSERT) ? dec.offset : '0;

    bfx_mask u_mask (
        .width (dec.width),
        .shift (mask_shift),
        .mask  (mask)
    );

    assign src_down = src >> dec.offset;
    assign src_up   = src << dec.offset;

    always_comb begin
        unique case (dec.op)
            OP_EXTRACT: value = src_down & mask;
            OP_INSERT:  value = (dst & ~mask) | (src_up & mask);
            default:    value = '0;
        endcase
    end
endmodule

// File: rtl/bitfield_xu.sv
module bitfield_xu
    import bfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      in_instr,
    input  logic [XLEN-1:0]  in_src,
    input  logic [XLEN-1:0]  in_dst,
    output logic [XLEN-1:0]  out_result,
    output logic [IDX_W-1:0] out_rd,
    output logic             out_we,
    output logic             out_illegal
);
    bf_dec_t         dec;
    logic [XLEN-1:0] dp_value;
    bf_out_t         st_d;
    bf_out_t         st_q;

    bfx_decode u_decode (
        .instr (in_instr),
        .dec   (dec)
    );

    bfx_datapath u_datapath (
        .dec   (dec),
        .src   (in_src),
        .dst   (in_dst),
        .value (dp_value)
    );

    always_comb begin
        st_d         = st_q;
        st_d.we      = 1'b0;
        st_d.illegal = 1'b0;
        if (in_valid) begin
            st_d.rd      = dec.rd;
            st_d.we      = dec.legal;
            st_d.illegal = ~dec.legal;
            st_d.result  = dec.legal ? dp_value : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_result  = st_q.result;
    assign out_rd      = st_q.rd;
    assign out_we      = st_q.we;
    assign out_illegal = st_q.illegal;
endmodule

// File: rtl/bfx_checker.sv
module bfx_checker
    import bfx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [31:0]      in_instr,
    input logic [XLEN-1:0]  in_src,
    input logic [XLEN-1:0]  out_result,
    input logic [IDX_W-1:0] out_rd,
    input logic             out_we,
    input logic             out_illegal
);
    logic req_ext;
    logic req_ins;
    assign req_ext = in_valid && ((in_instr & CLASS_MASK) == EXTRACT_PAT);
    assign req_ins = in_valid && ((in_instr & CLASS_MASK) == INSERT_PAT);

    assert_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        out_we |-> !out_illegal);

    assert_one_bit_extract_R2: assert property (@(posedge clk) disable iff (rst)
        req_ext && in_instr[10:6] == 5'd1 |=> out_result[XLEN-1:1] == '0);

    assert_rd_follows_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_rd == $past(in_instr[25:21]));

    assert_zero_width_R5: assert property (@(posedge clk) disable iff (rst)
        req_ext && in_instr[10:6] == 5'd0 |=> out_illegal && !out_we);

    assert_inverted_insert_R7: assert property (@(posedge clk) disable iff (rst)
        req_ins && in_instr[10:6] < in_instr[4:0] |=> out_illegal && !out_we);

    assert_foreign_opcode_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_instr[31:26] != 6'h19 |=> out_illegal && !out_we);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_we && !out_illegal && $stable(out_result));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> !out_we && !out_illegal && out_result == '0);

    assert_full_insert_R11: assert property (@(posedge clk) disable iff (rst)
        req_ins && in_instr[10:6] == 5'd31 && in_instr[4:0] == 5'd0
        |=> out_we && out_result == $past(in_src));
endmodule

bind bitfield_xu bfx_checker u_bfx_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_instr    (in_instr),
    .in_src      (in_src),
    .out_result  (out_result),
    .out_rd      (out_rd),
    .out_we      (out_we),
    .out_illegal (out_illegal)
);

// File: tb/tb_bitfield_xu.sv
module tb_bitfield_xu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_src = '0;
    logic [31:0] in_dst = '0;
    logic [31:0] out_result;
    logic [4:0]  out_rd;
    logic        out_we;
    logic        out_illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [31:0] exp_res = '0;
    logic [4:0]  exp_rd  = '0;

    always #4 clk = ~clk;

    bitfield_xu dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_src(in_src), .in_dst(in_dst), .out_result(out_result),
        .out_rd(out_rd), .out_we(out_we), .out_illegal(out_illegal)
    );

    function automatic logic [31:0] mk(int kind, logic [4:0] rd, logic [4:0] ra,
                                       logic [4:0] imm, logic [4:0] off);
        logic [31:0] base;
        base = (kind == 0) ? 32'h6400_4000 : 32'h6400_8000;
        return base | {6'd0, rd, ra, 16'd0} | {21'd0, imm, 6'd0} | {27'd0, off};
    endfunction

    // Reference: returns {illegal, we, result}
    function automatic logic [33:0] ref_model(logic [31:0] w, logic [31:0] s, logic [31:0] d);
        logic [31:0] r;
        int imm, off;
        imm = int'(w[10:6]);
        off = int'(w[4:0]);
        r = '0;
        if (w[31:26] == 6'h19 && w[15:14] == 2'b01) begin
            if (imm == 0 || imm + off > 32) return {2'b10, 32'd0};
            for (int i = 0; i < imm; i++) r[i] = s[i + off];
            return {2'b01, r};
        end
        if (w[31:26] == 6'h19 && w[15:14] == 2'b10) begin
            if (imm < off) return {2'b10, 32'd0};
            for (int i = 0; i < 32; i++)
                r[i] = (i >= off && i <= imm) ? s[i - off] : d[i];
            return {2'b01, r};
        end
        return {2'b10, 32'd0};
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run(string req, bit v, logic [31:0] w, logic [31:0] s, logic [31:0] d);
        logic [33:0] m;
        in_valid = v; in_instr = w; in_src = s; in_dst = d;
        @(negedge clk);
        if (v) begin
            m = ref_model(w, s, d);
            exp_res = m[31:0];
            exp_rd  = w[25:21];
            check(req, {24'd0, out_illegal, out_we, out_rd, out_result},
                  {24'd0, m[33], m[32], exp_rd, exp_res});
        end else begin
            check({req, " R9 idle"}, {24'd0, out_illegal, out_we, out_rd, out_result},
                  {24'd0, 1'b0, 1'b0, exp_rd, exp_res});
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R10 reset", {26'd0, out_illegal, out_we, out_rd, out_result}, 64'd0);
        rst = 1'b0;

        // R2 extract offset 0, width 1 and width 31
        run("R2 ext w1 off0",   1, mk(0, 5'd3, 5'd1, 5'd1, 5'd0), 32'hFFFF_FFFF, 32'h0);
        run("R2 ext w31 off0",  1, mk(0, 5'd4, 5'd1, 5'd31, 5'd0), 32'hDEAD_BEEF, 32'h0);
        run("R2 ext w31 off1",  1, mk(0, 5'd5, 5'd1, 5'd31, 5'd1), 32'hDEAD_BEEF, 32'h0);
        run("R2 ext w8 off12",  1, mk(0, 5'd6, 5'd1, 5'd8, 5'd12), 32'h1234_5678, 32'h0);
        // R11 full insert and R3 narrow insert
        run("R11 ins full",     1, mk(1, 5'd7, 5'd2, 5'd31, 5'd0), 32'hCAFE_F00D, 32'h5555_5555);
        run("R3 ins 4b at 8",   1, mk(1, 5'd8, 5'd2, 5'd11, 5'd8), 32'h0000_000A, 32'hFFFF_FFFF);
        run("R3 ins 1b at 31",  1, mk(1, 5'd9, 5'd2, 5'd31, 5'd31), 32'h0000_0000, 32'hFFFF_FFFF);
        // Rejected encodings
        run("R5 ext w0",        1, mk(0, 5'd10, 5'd1, 5'd0, 5'd3), 32'hFFFF_FFFF, 32'h0);
        run("R6 ext overflow",  1, mk(0, 5'd11, 5'd1, 5'd20, 5'd13), 32'hFFFF_FFFF, 32'h0);
        run("R7 ins inverted",  1, mk(1, 5'd12, 5'd1, 5'd4, 5'd5), 32'hFFFF_FFFF, 32'h0);
        run("R8 bits15_14=11",  1, 32'h6400_C000 | (32'd13 << 21), 32'h1, 32'h2);
        run("R8 bits15_14=00",  1, 32'h6400_0000 | (32'd14 << 21), 32'h1, 32'h2);
        run("R8 other opcode",  1, 32'h8000_4000 | (32'd15 << 21), 32'h1, 32'h2);
        run("R4 R9 idle",       0, 32'h6400_4041, 32'h1, 32'h2);
        run("R4 ext rd31",      1, mk(0, 5'd31, 5'd1, 5'd5, 5'd27), 32'hF800_0000, 32'h0);

        for (int k = 0; k < 600; k++) begin
            int kind;
            logic [31:0] w;
            logic [4:0] imm, off;
            kind = int'($urandom % 4);
            imm  = 5'($urandom);
            off  = 5'($urandom);
            if ($urandom % 4 == 0) imm = ($urandom % 2) ? 5'd31 : 5'd0;
            if (kind < 2) w = mk(kind, 5'($urandom), 5'($urandom), imm, off);
            else if (kind == 2) w = {6'h19, 8'($urandom), 2'(($urandom % 2) * 3), 16'($urandom)} ;
            else w = $urandom;
            run("R1 R2 R3 random", ($urandom % 8) != 0, w, $urandom, $urandom);
        end

        rst = 1'b1;
        @(negedge clk);
        check("R10 reset again", {26'd0, out_illegal, out_we, out_rd, out_result}, 64'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule